// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block sits behind the bus port of a parallel NOR flash model. It watches every bus write, each an address with data, and runs the multi-write command protocol that guards the array. It keeps track of the current write step, the command being built and an unlock-bypass flag. From these it starts three operations on a small on-chip word array: word program, which can only clear bits; sector erase; and chip erase. Both erases fill their range with ones. It also chooses what a bus read returns: array data, identification words, a status byte or a query table.

Addresses arrive as byte addresses. They are turned into word offsets by dropping one low bit for a 16-bit device, two for a 32-bit device and none for an 8-bit device. All protocol comparisons use the word offset. Erase busy time is modelled by a cycle counter whose two lengths are parameters. A read-only input lets the protocol run as normal while keeping the array unchanged.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset every array word reads 0xFFFF, `busy` is 0 and `rd_mode` is 0. The `rd_mode` encoding is 0 for array, 1 for identification, 2 for status and 3 for query.
- R2: Byte addresses are shifted right by 1 (DATA_W=16) to form word offsets before any comparison, so an unlock write at byte address 0x55 (word 0x2A) does not match the first unlock word 0x55.
- R3: Unlock is data 0xAA at word UNLOCK_A (0x55), then data 0x55 at word UNLOCK_B (0xAA). Any other write in either step returns to array mode, and the following writes do not program.
- R4: Outside bypass, the command write after unlock must hit word UNLOCK_A, or the sequence aborts. In that write, 0xA0 selects program, 0x90 identification, 0x80 erase setup and 0x20 bypass, and any other value aborts. While program waits for its data, `rd_mode` is 2.
- R5: The program data write ANDs the data into the addressed word, so bits only go from 1 to 0. The status byte becomes {~data[7], 7'b0}. The sequencer then returns to array mode, or to the command step when bypass is on.
- R6: Data 0xF0 written at any step returns to array mode and clears bypass. While program waits for its data, 0xF0 is instead programmed as data.
- R7: In array mode, data 0x98 at word 0x55 enters query mode (`rd_mode`=3). There, word 0x10/0x11/0x12 read 0x0051/0x0052/0x0059 and word 0x27 reads log2 of the array size in bytes (7). Any write leaves query mode. Query can also be entered from identification mode with the same write.
- R8: In identification mode, word 0 reads ID_MFR (0x0001), word 1 reads ID_DEV (0x227E), word 2 reads 0 and every other word reads the array.
- R9: After erase setup and a second unlock, data 0x30 at any word erases that word's sector (WORDS_PER_SECTOR words) to 0xFFFF. Status is cleared and `busy` is high for SECTOR_BUSY_CYC (20) cycles. When busy ends, status bit 7 inverts and `rd_mode` returns to 0.
- R10: After erase setup and a second unlock, data 0x10 at word UNLOCK_A erases the whole array, with `busy` high for CHIP_BUSY_CYC (200) cycles.
- R11: While `busy` is high every write is ignored, 0xF0 included, and `rd_mode` reads 2.
- R12: In bypass, program needs only 0xA0 at any address followed by the data. 0x90 followed by 0x00 leaves bypass, after which a bare 0xA0 no longer programs.
- R13: With `read_only` high, program and erase run their full sequences, including status updates and busy time, but the array is unchanged.
- R14: In status mode, `rd_data` is {8'h00, status}, and each read with `rd_en` high inverts status bit 6 after it is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | DATA_W | Write data; the command code is in bits 7:0 |
| read_only | input | 1 | Blocks array changes from program and erase |
| rd_en | input | 1 | Bus read strobe, used to toggle the status bit |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | DATA_W | Read data for the current read mode |
| rd_mode | output | 2 | Current read mode |
| busy | output | 1 | Erase in progress |

## Verification
The hardest case to reach is a write that arrives while an erase is busy. The timer has to be running, and the write must be one that would change state or the array if it were accepted. The stimulus starts a sector erase, reads status twice to see the toggling bit, and then sends a complete unlock, program and data sequence plus an 0xF0 before the counter expires. The word targeted by that sequence must still read 0xFFFF afterwards. Status bit 7 flipping at the end of an erase is seen by opening a new program sequence and reading status before sending its data.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [3:0] {
        S_READ, S_UNLOCK2, S_COMMAND, S_PROG_DATA, S_AUTOSEL,
        S_ERASE_UNL1, S_ERASE_UNL2, S_ERASE_CMD, S_ERASING, S_QUERY
    } seq_state_e;

    typedef enum logic [1:0] {
        MODE_ARRAY  = 2'd0,
        MODE_IDENT  = 2'd1,
        MODE_STATUS = 2'd2,
        MODE_QUERY  = 2'd3
    } read_mode_e;

    typedef enum logic [1:0] {
        OP_NONE, OP_PROGRAM, OP_SECTOR, OP_CHIP
    } array_op_e;

    typedef struct packed {
        seq_state_e  state;
        logic        bypass;
        logic [7:0]  status;
    } seq_regs_t;

    localparam logic [7:0] CMD_RESET   = 8'hF0;
    localparam logic [7:0] CMD_QUERY   = 8'h98;
    localparam logic [7:0] CMD_KEY1    = 8'hAA;
    localparam logic [7:0] CMD_KEY2    = 8'h55;
    localparam logic [7:0] CMD_BYPASS  = 8'h20;
    localparam logic [7:0] CMD_SETUP   = 8'h80;
    localparam logic [7:0] CMD_IDENT   = 8'h90;
    localparam logic [7:0] CMD_PROGRAM = 8'hA0;
    localparam logic [7:0] CMD_CHIP    = 8'h10;
    localparam logic [7:0] CMD_SECTOR  = 8'h30;
    localparam logic [7:0] CMD_EXIT    = 8'h00;
    localparam int         QUERY_WORD  = 'h55;

    function automatic int width_shift(input int data_w);
        return (data_w == 32) ? 2 : (data_w == 16) ? 1 : 0;
    endfunction

endpackage

// File: rtl/flash_busy_timer.sv
module flash_busy_timer #(
    parameter int SECTOR_CYC = 20,
    parameter int CHIP_CYC   = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic start_sector,
    input  logic start_chip,
    output logic busy,
    output logic done
);
    localparam int CNT_W = $clog2(CHIP_CYC + 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)               cnt <= '0;
        else if (start_chip)   cnt <= CNT_W'(CHIP_CYC);
        else if (start_sector) cnt <= CNT_W'(SECTOR_CYC);
        else if (cnt != '0)    cnt <= cnt - CNT_W'(1);
    end

    assign busy = (cnt != '0);
    assign done = (cnt == CNT_W'(1));
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
    import flash_seq_pkg::*;
#(
    parameter int               WOFS_W = 8,
    parameter logic [WOFS_W-1:0] UNL_A = 'h55,
    parameter logic [WOFS_W-1:0] UNL_B = 'hAA
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WOFS_W-1:0] wofs,
    input  logic [7:0]        cmd,
    input  logic              read_only,
    input  logic              erase_done,
    input  logic              status_read,
    output array_op_e         op,
    output logic              start_sector,
    output logic              start_chip,
    output read_mode_e        mode,
    output logic [7:0]        status
);
    localparam logic [WOFS_W-1:0] QRY_OFS = WOFS_W'(QUERY_WORD);

    seq_regs_t cur, nxt;
    logic      abort;

    always_comb begin
        nxt          = cur;
        op           = OP_NONE;
        start_sector = 1'b0;
        start_chip   = 1'b0;
        abort        = 1'b0;
        if (status_read) nxt.status[6] = ~cur.status[6];
        if (cur.state == S_ERASING) begin
            if (erase_done) begin
                nxt.status[7] = ~nxt.status[7];
                nxt.state     = cur.bypass ? S_COMMAND : S_READ;
            end
        end else if (wr_en) begin
            if (cmd == CMD_RESET && cur.state != S_PROG_DATA) begin
                abort = 1'b1;
            end else begin
                case (cur.state)
                    S_READ: begin
                        if (wofs == QRY_OFS && cmd == CMD_QUERY) nxt.state = S_QUERY;
                        else if (wofs == UNL_A && cmd == CMD_KEY1) nxt.state = S_UNLOCK2;
                        else abort = 1'b1;
                    end
                    S_UNLOCK2, S_ERASE_UNL2: begin
                        if (wofs == UNL_B && cmd == CMD_KEY2)
                            nxt.state = (cur.state == S_UNLOCK2) ? S_COMMAND : S_ERASE_CMD;
                        else abort = 1'b1;
                    end
                    S_COMMAND: begin
                        if (!cur.bypass && wofs != UNL_A) abort = 1'b1;
                        else begin
                            case (cmd)
                                CMD_BYPASS:  nxt.bypass = 1'b1;
                                CMD_SETUP:   nxt.state  = S_ERASE_UNL1;
                                CMD_IDENT:   nxt.state  = S_AUTOSEL;
                                CMD_PROGRAM: nxt.state  = S_PROG_DATA;
                                default:     abort      = 1'b1;
                            endcase
                        end
                    end
                    S_PROG_DATA: begin
                        op         = read_only ? OP_NONE : OP_PROGRAM;
                        nxt.status = {~cmd[7], 7'b0};
                        nxt.state  = cur.bypass ? S_COMMAND : S_READ;
                    end
                    S_AUTOSEL: begin
                        if (wofs == QRY_OFS && cmd == CMD_QUERY) nxt.state = S_QUERY;
                        else abort = 1'b1;
                    end
                    S_ERASE_UNL1: begin
                        if (wofs == UNL_A && cmd == CMD_KEY1) nxt.state = S_ERASE_UNL2;
                        else abort = 1'b1;
                    end
                    S_ERASE_CMD: begin
                        if (cmd == CMD_CHIP && wofs == UNL_A) begin
                            start_chip = 1'b1;
                            op         = read_only ? OP_NONE : OP_CHIP;
                            nxt.status = 8'h00;
                            nxt.state  = S_ERASING;
                        end else if (cmd == CMD_SECTOR) begin
                            start_sector = 1'b1;
                            op           = read_only ? OP_NONE : OP_SECTOR;
                            nxt.status   = 8'h00;
                            nxt.state    = S_ERASING;
                        end else abort = 1'b1;
                    end
                    default: abort = 1'b1;
                endcase
            end
        end
        if (abort) begin
            nxt.state  = S_READ;
            nxt.bypass = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= '{state: S_READ, bypass: 1'b0, status: 8'h00};
        else     cur <= nxt;
    end

    always_comb begin
        case (cur.state)
            S_AUTOSEL:              mode = MODE_IDENT;
            S_QUERY:                mode = MODE_QUERY;
            S_PROG_DATA, S_ERASING: mode = MODE_STATUS;
            default:                mode = MODE_ARRAY;
        endcase
    end

    assign status = cur.status;
endmodule

// File: rtl/flash_word_array.sv
module flash_word_array
    import flash_seq_pkg::*;
#(
    parameter int DATA_W           = 16,
    parameter int WORDS_PER_SECTOR = 16,
    parameter int NUM_SECTORS      = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  array_op_e             op,
    input  logic [$clog2(WORDS_PER_SECTOR*NUM_SECTORS)-1:0] wr_idx,
    input  logic [DATA_W-1:0]     wr_word,
    input  logic [$clog2(WORDS_PER_SECTOR*NUM_SECTORS)-1:0] rd_idx,
    output logic [DATA_W-1:0]     rd_word
);
    localparam int NUM_WORDS = WORDS_PER_SECTOR * NUM_SECTORS;
    localparam int IDX_W     = $clog2(NUM_WORDS);
    localparam int SEC_W     = $clog2(WORDS_PER_SECTOR);

    logic [DATA_W-1:0] words [NUM_WORDS];

    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);
        logic [DATA_W-1:0] word_q;
        logic              in_sector;

        assign in_sector = ((wr_idx >> SEC_W) == (MY_IDX >> SEC_W));

        always_ff @(posedge clk) begin
            if (rst) word_q <= '1;
            else begin
                case (op)
                    OP_PROGRAM: if (wr_idx == MY_IDX) word_q <= word_q & wr_word;
                    OP_SECTOR:  if (in_sector) word_q <= '1;
                    OP_CHIP:    word_q <= '1;
                    default:    ;
                endcase
            end
        end
        assign words[i] = word_q;
    end

    assign rd_word = words[rd_idx];
endmodule

// File: rtl/flash_read_mux.sv
module flash_read_mux
    import flash_seq_pkg::*;
#(
    parameter int          DATA_W    = 16,
    parameter int          WOFS_W    = 8,
    parameter int          SIZE_LOG2 = 7,
    parameter logic [15:0] ID_MFR    = 16'h0001,
    parameter logic [15:0] ID_DEV    = 16'h227E
) (
    input  read_mode_e        mode,
    input  logic [WOFS_W-1:0] rd_wofs,
    input  logic [DATA_W-1:0] array_word,
    input  logic [7:0]        status,
    output logic [DATA_W-1:0] rd_data
);
    always_comb begin
        case (mode)
            MODE_STATUS: rd_data = DATA_W'(status);
            MODE_IDENT: begin
                case (rd_wofs)
                    WOFS_W'('h00): rd_data = DATA_W'(ID_MFR);
                    WOFS_W'('h01): rd_data = DATA_W'(ID_DEV);
                    WOFS_W'('h02): rd_data = '0;
                    default:       rd_data = array_word;
                endcase
            end
            MODE_QUERY: begin
                case (rd_wofs)
                    WOFS_W'('h10): rd_data = DATA_W'(8'h51);
                    WOFS_W'('h11): rd_data = DATA_W'(8'h52);
                    WOFS_W'('h12): rd_data = DATA_W'(8'h59);
                    WOFS_W'('h13): rd_data = DATA_W'(8'h02);
                    WOFS_W'('h27): rd_data = DATA_W'(SIZE_LOG2);
                    default:       rd_data = '0;
                endcase
            end
            default: rd_data = array_word;
        endcase
    end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_seq_pkg::*;
#(
    parameter int          DATA_W           = 16,
    parameter int          ADDR_W           = 9,
    parameter int          WORDS_PER_SECTOR = 16,
    parameter int          NUM_SECTORS      = 4,
    parameter int          UNLOCK_A         = 'h55,
    parameter int          UNLOCK_B         = 'hAA,
    parameter logic [15:0] ID_MFR           = 16'h0001,
    parameter logic [15:0] ID_DEV           = 16'h227E,
    parameter int          SECTOR_BUSY_CYC  = 20,
    parameter int          CHIP_BUSY_CYC    = 200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              read_only,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [1:0]        rd_mode,
    output logic              busy
);
    localparam int SHIFT     = width_shift(DATA_W);
    localparam int WOFS_W    = ADDR_W - SHIFT;
    localparam int NUM_WORDS = WORDS_PER_SECTOR * NUM_SECTORS;
    localparam int IDX_W     = $clog2(NUM_WORDS);
    localparam int SIZE_LOG2 = $clog2(NUM_WORDS * DATA_W / 8);
    localparam logic [WOFS_W-1:0] UNL_A = WOFS_W'(UNLOCK_A);
    localparam logic [WOFS_W-1:0] UNL_B = WOFS_W'(UNLOCK_B);

    logic [WOFS_W-1:0] wr_wofs, rd_wofs;
    logic [DATA_W-1:0] array_word;
    logic [7:0]        status;
    array_op_e         op;
    read_mode_e        mode;
    logic              start_sector, start_chip, erase_done;

    assign wr_wofs = wr_addr[ADDR_W-1:SHIFT];
    assign rd_wofs = rd_addr[ADDR_W-1:SHIFT];

    if (SHIFT > 0) begin : g_lsb
        logic unused_lsbs;
        assign unused_lsbs = ^{wr_addr[SHIFT-1:0], rd_addr[SHIFT-1:0]};
    end

    flash_cmd_fsm #(.WOFS_W(WOFS_W), .UNL_A(UNL_A), .UNL_B(UNL_B)) i_fsm (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wofs(wr_wofs), .cmd(wr_data[7:0]),
        .read_only(read_only), .erase_done(erase_done),
        .status_read(rd_en && mode == MODE_STATUS),
        .op(op), .start_sector(start_sector), .start_chip(start_chip),
        .mode(mode), .status(status)
    );

    flash_busy_timer #(.SECTOR_CYC(SECTOR_BUSY_CYC), .CHIP_CYC(CHIP_BUSY_CYC)) i_timer (
        .clk(clk), .rst(rst), .start_sector(start_sector), .start_chip(start_chip),
        .busy(busy), .done(erase_done)
    );

    flash_word_array #(.DATA_W(DATA_W), .WORDS_PER_SECTOR(WORDS_PER_SECTOR),
                       .NUM_SECTORS(NUM_SECTORS)) i_array (
        .clk(clk), .rst(rst), .op(op), .wr_idx(wr_wofs[IDX_W-1:0]), .wr_word(wr_data),
        .rd_idx(rd_wofs[IDX_W-1:0]), .rd_word(array_word)
    );

    flash_read_mux #(.DATA_W(DATA_W), .WOFS_W(WOFS_W), .SIZE_LOG2(SIZE_LOG2),
                     .ID_MFR(ID_MFR), .ID_DEV(ID_DEV)) i_mux (
        .mode(mode), .rd_wofs(rd_wofs), .array_word(array_word),
        .status(status), .rd_data(rd_data)
    );

    assign rd_mode = mode;
endmodule

// File: rtl/flash_cmd_seq_checker.sv
module flash_cmd_seq_checker
    import flash_seq_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic [1:0]        rd_mode,
    input logic              busy
);
    AST_BUSY_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(wr_en)); // R9

    AST_BUSY_STATUS_MODE: assert property (@(posedge clk) disable iff (rst)
        busy |-> rd_mode == MODE_STATUS); // R11

    AST_BUSY_END_ARRAY: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> rd_mode == MODE_ARRAY); // R9

    AST_RESET_CODE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[7:0] == CMD_RESET && !busy && rd_mode != MODE_STATUS)
        |=> rd_mode == MODE_ARRAY); // R6

    AST_QUERY_EXIT: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rd_mode == MODE_QUERY) |=> rd_mode == MODE_ARRAY); // R7
endmodule

bind flash_cmd_seq flash_cmd_seq_checker #(.DATA_W(DATA_W)) i_checker (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_mode(rd_mode), .busy(busy)
);

// File: tb/test_flash_cmd_seq.sv
module test_flash_cmd_seq;
    localparam int CLK_PERIOD = 10;
    localparam int UA = 'h55;
    localparam int UB = 'hAA;
    localparam int WPS = 16;
    localparam int SECT_CYC = 20;
    localparam int CHIP_CYC = 200;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [8:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        read_only = 1'b0;
    logic        rd_en = 1'b0;
    logic [8:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic [1:0]  rd_mode;
    logic        busy;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [15:0] exp_q [$];
    string       tag_q [$];
    logic [15:0] model [64];
    logic [7:0]  st;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_cmd_seq i_flash_cmd_seq (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .read_only(read_only), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .rd_mode(rd_mode), .busy(busy)
    );

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wrb(input int baddr, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 9'(baddr); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr(input int w, input logic [15:0] d);
        wrb(w << 1, d);
    endtask

    task automatic rd(input int w, input logic [15:0] exp, input string tag);
        @(negedge clk);
        rd_addr = 9'(w << 1); rd_en = 1'b1;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic rd_arr(input int w, input string tag);
        rd(w, model[w], tag);
    endtask

    task automatic rd_stat(input string tag);
        rd(0, {8'h00, st}, tag);
        st ^= 8'h40;
    endtask

    task automatic unlock();
        wr(UA, 16'h00AA);
        wr(UB, 16'h0055);
    endtask

    task automatic data_cycle(input int w, input logic [15:0] d);
        wr(w, d);
        if (!read_only) model[w] &= d;
        st = {~d[7], 7'b0};
    endtask

    task automatic prog(input int w, input logic [15:0] d);
        unlock();
        wr(UA, 16'h00A0);
        data_cycle(w, d);
    endtask

    task automatic erase_start(input int w, input bit chip);
        unlock();
        wr(UA, 16'h0080);
        unlock();
        if (chip) wr(UA, 16'h0010);
        else      wr(w, 16'h0030);
        st = 8'h00;
        if (!read_only) begin
            for (int i = 0; i < 64; i++)
                if (chip || (i / WPS) == (w / WPS)) model[i] = 16'hFFFF;
        end
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
        st ^= 8'h80;
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            if (rd_en) begin
                if (exp_q.size() == 0) check(rd_data, 16'hxxxx, "monitor queue empty");
                else check(rd_data, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stimulus
        int n;
        for (int i = 0; i < 64; i++) model[i] = 16'hFFFF;
        st = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check(16'(busy), 16'h0, "R1 busy after reset");
        check(16'(rd_mode), 16'h0, "R1 mode after reset");
        rd_arr(0, "R1 word 0");
        rd_arr(63, "R1 word 63");

        // R5 / R14 program with status reads while data pending
        unlock();
        wr(UA, 16'h00A0);
        check(16'(rd_mode), 16'h2, "R4 status mode while program waits");
        rd_stat("R14 first status read");
        rd_stat("R14 toggled status read");
        data_cycle(8, 16'h1234);
        rd_arr(8, "R5 programmed word");
        unlock();
        wr(UA, 16'h00A0);
        rd_stat("R5 status bit7 inverse");
        data_cycle(8, 16'hFF0F);
        rd_arr(8, "R5 program only clears bits");

        // R3 bad second unlock
        wr(UA, 16'h00AA);
        wr(UB, 16'h0056);
        wr(UA, 16'h00A0);
        wr(8, 16'h0000);
        check(16'(rd_mode), 16'h0, "R3 mode after mismatch");
        rd_arr(8, "R3 no program after mismatch");

        // R4 command at wrong address
        unlock();
        wr('h10, 16'h00A0);
        wr(8, 16'h0000);
        rd_arr(8, "R4 command off unlock word");

        // R2 unshifted byte address does not unlock
        wrb('h55, 16'h00AA);
        wr(UB, 16'h0055);
        wr(UA, 16'h00A0);
        wr(8, 16'h0000);
        rd_arr(8, "R2 byte address shift");

        // R6 reset code as program data, then as abort
        prog(9, 16'h00F0);
        rd_arr(9, "R6 reset code programmed as data");
        unlock();
        wr(UA, 16'h00F0);
        wr(UA, 16'h00A0);
        wr(9, 16'h0000);
        rd_arr(9, "R6 reset code aborts sequence");

        // R7 query
        wr('h55, 16'h0098);
        check(16'(rd_mode), 16'h3, "R7 query mode");
        rd('h10, 16'h0051, "R7 query Q");
        rd('h11, 16'h0052, "R7 query R");
        rd('h27, 16'h0007, "R7 query size");
        wr(0, 16'h0000);
        check(16'(rd_mode), 16'h0, "R7 query exit");
        rd_arr('h10, "R7 array after query exit");

        // R8 identification
        unlock();
        wr(UA, 16'h0090);
        rd(0, 16'h0001, "R8 manufacturer id");
        rd(1, 16'h227E, "R8 device id");
        rd(2, 16'h0000, "R8 protect word");
        rd_arr(8, "R8 array passthrough");
        wr('h55, 16'h0098);
        rd('h12, 16'h0059, "R7 query from ident");
        wr(0, 16'h00F0);
        check(16'(rd_mode), 16'h0, "R6 reset from query");

        // R12 bypass
        unlock();
        wr(UA, 16'h0020);
        wr('h30, 16'h00A0);
        data_cycle(3, 16'h0F0F);
        wr('h31, 16'h00A0);
        data_cycle(4, 16'h3333);
        check(16'(rd_mode), 16'h0, "R12 array mode in bypass");
        rd_arr(3, "R12 bypass program 1");
        rd_arr(4, "R12 bypass program 2");
        wr('h30, 16'h0090);
        wr('h30, 16'h0000);
        wr('h30, 16'h00A0);
        wr(5, 16'h0000);
        rd_arr(5, "R12 bypass left");

        // R9 sector erase timing
        prog(20, 16'hA5A5);
        erase_start(9, 1'b0);
        check(16'(busy), 16'h1, "R9 busy after sector erase");
        wait_idle(n);
        check(16'(n), 16'(SECT_CYC), "R9 sector busy cycles");
        rd_arr(8, "R9 sector word 8 erased");
        rd_arr(3, "R9 sector word 3 erased");
        rd_arr(20, "R9 other sector kept");

        // R11 writes ignored while busy
        erase_start(20, 1'b0);
        rd_stat("R9 status cleared on erase");
        rd_stat("R14 status toggles during erase");
        wr(UA, 16'h00F0);
        unlock();
        wr(UA, 16'h00A0);
        wr(21, 16'h0000);
        check(16'(busy), 16'h1, "R11 still busy");
        wait_idle(n);
        rd_arr(21, "R11 program ignored while busy");
        rd_arr(20, "R9 second sector erased");
        unlock();
        wr(UA, 16'h00A0);
        rd_stat("R9 status bit7 flips at end");
        data_cycle(22, 16'hFFFF);

        // R10 chip erase
        prog(40, 16'h1234);
        erase_start(0, 1'b1);
        check(16'(busy), 16'h1, "R10 busy after chip erase");
        wait_idle(n);
        check(16'(n), 16'(CHIP_CYC), "R10 chip busy cycles");
        rd_arr(40, "R10 word 40 erased");
        rd_arr(4, "R10 word 4 erased");

        // R13 read-only
        prog(30, 16'h5A5A);
        read_only = 1'b1;
        prog(30, 16'h0000);
        rd_arr(30, "R13 program blocked");
        unlock();
        wr(UA, 16'h00A0);
        rd_stat("R13 status still updated");
        data_cycle(31, 16'hFFFF);
        erase_start(30, 1'b0);
        check(16'(busy), 16'h1, "R13 erase still timed");
        wait_idle(n);
        rd_arr(30, "R13 erase blocked");
        read_only = 1'b0;

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule